// File: doc/BRIEF.md
# Framing-Bit Rolling Pattern Inserter

This block sits in the transmit path of a T1 framer. For each frame it takes the framing (F) bit that the upstream frame formatter produced and may replace it with a bit taken from a small pattern store that software loads. The store holds six 6-bit words, which make a 36-bit pattern as long as one Fs multiframe. Each time a frame of the selected parity arrives, the next pattern bit is used. The pointer wraps after the last bit, so the pattern repeats with no further software action.

Software selects even frames (the Fs positions, for a concentrator-style signalling pattern) or odd frames (the positions that carry the facility data link). A per-position enable mask picks which bits of each word are actually inserted. The F bit passes through unchanged at the other positions and on frames of the other parity. Software may rewrite any word at any moment. A new value takes effect only at the next word boundary, so no word is ever sent half old and half new. A multiframe start strobe realigns the pointer to the first bit of the first word.

Top module: `fbit_pattern_ins`

## Requirements
- R1: After reset, `f_out` and `f_out_vld` are 0, all six pattern words are 0 and the pointer is at word 0, bit 0.
- R2: With `wr_en` high, `wr_data` is stored in word `wr_addr` (0 to 5). A write to address 6 or 7 changes no word.
- R3: On a frame whose `frame_odd` equals `odd_sel`, with the position enabled, `f_out` is the pattern bit. Words are sent in order 0 to 5, and each word is sent most-significant bit first (bit 5 first, bit 0 last).
- R4: After the 36th selected frame the pointer returns to word 0, bit 0, and the pattern repeats with no write.
- R5: On a frame whose `frame_odd` differs from `odd_sel`, `f_out` equals `f_in` and the pointer does not move.
- R6: `odd_sel` = 1 selects odd frames (`frame_odd` = 1) for insertion, and `odd_sel` = 0 selects even frames.
- R7: `bit_en[k]` applies to the k-th bit sent in each word (k = 0 is the most-significant bit). When that enable is 0, `f_out` equals `f_in`, but the pointer still advances.
- R8: A word is captured when its first bit is sent. A write to that word while its other bits are being sent does not change them. A write to that word in the same cycle as its first bit is sent is used at once.
- R9: `mf_start` given with `f_valid` resets the pointer. That frame, if selected, sends word 0, bit 0. If it is not selected, the next selected frame does.
- R10: `f_out` and `f_out_vld` are registered and appear one clock after `f_valid`. In cycles without `f_valid`, `f_out_vld` is 0 and `f_out` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Pattern word write strobe |
| wr_addr | input | 3 | Pattern word index, 0 to 5 |
| wr_data | input | 6 | Pattern word value, bit 5 sent first |
| odd_sel | input | 1 | 0: insert on even frames, 1: insert on odd frames |
| bit_en | input | 6 | Per-position insert enables; bit k covers the k-th bit sent |
| f_valid | input | 1 | A frame's F bit is present this cycle |
| frame_odd | input | 1 | Parity of the current frame |
| mf_start | input | 1 | Multiframe start; qualified by f_valid |
| f_in | input | 1 | F bit from the upstream formatter |
| f_out | output | 1 | F bit after insertion |
| f_out_vld | output | 1 | f_out carries a new frame's bit |

## Verification
A software write and the capture of a word at its first bit can fall in the same cycle. The bench provokes this by placing the pointer on the last bit of a word, so that the next selected frame arrives together with a write to the word about to be captured. The bench expects the written value to be sent at once. A same-cycle write to a different word must not disturb the word being captured. A write that arrives in the middle of a word is also checked: the word keeps its old bits until the pointer wraps around to it again. The multiframe strobe is also driven on frames of the other parity and in the middle of a word, to confirm that realignment and pass-through act together.

// File: rtl/fbit_ins_pkg.sv
package fbit_ins_pkg;

   // width of an index able to address n items
   function automatic int idx_w(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // parity selection encoding shared with the configuration input
   typedef enum logic {
      SEL_EVEN = 1'b0,
      SEL_ODD  = 1'b1
   } fpar_e;

endpackage

// File: rtl/fbit_pat_store.sv
module fbit_pat_store #(
   parameter int WORD_W  = 6,
   parameter int N_WORDS = 6,
   parameter int AW      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_word
);

   logic [N_WORDS-1:0][WORD_W-1:0] mem;

   generate
      for (genvar g = 0; g < N_WORDS; g++) begin : g_word
         logic [WORD_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && (wr_addr == AW'(g)))
               q <= wr_data;
         end
         assign mem[g] = q;
      end
   endgenerate

   // read with same-cycle write forwarding
   always_comb begin
      rd_word = '0;
      for (int i = 0; i < N_WORDS; i++) begin
         if (rd_addr == AW'(i))
            rd_word = mem[i];
      end
      if (wr_en && (wr_addr == rd_addr))
         rd_word = wr_data;
   end

   assert_oob_write_ignored_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (int'(wr_addr) >= N_WORDS)) |=> $stable(mem));

   assert_write_lands_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (int'(wr_addr) < N_WORDS)) |=> (mem[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/fbit_pat_ptr.sv
module fbit_pat_ptr #(
   parameter int WORD_W  = 6,
   parameter int N_WORDS = 6,
   parameter int AW      = 3,
   parameter int BW      = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          f_valid,
   input  logic          match,
   input  logic          mf_start,
   output logic [AW-1:0] word_idx,
   output logic [BW-1:0] bit_idx,
   output logic          first_bit
);

   logic [AW-1:0] wp;
   logic [BW-1:0] bp;
   logic          last_bit;
   logic          last_word;

   // multiframe strobe overrides the stored position for this frame
   assign word_idx  = (f_valid && mf_start) ? '0 : wp;
   assign bit_idx   = (f_valid && mf_start) ? '0 : bp;
   assign first_bit = (bit_idx == '0);
   assign last_bit  = (bit_idx == BW'(WORD_W - 1));
   assign last_word = (word_idx == AW'(N_WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         bp <= '0;
      end else if (f_valid) begin
         if (match) begin
            if (last_bit) begin
               bp <= '0;
               wp <= last_word ? '0 : word_idx + 1'b1;
            end else begin
               bp <= bit_idx + 1'b1;
               wp <= word_idx;
            end
         end else begin
            bp <= bit_idx;
            wp <= word_idx;
         end
      end
   end

   assert_ptr_range_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (int'(bp) < WORD_W) && (int'(wp) < N_WORDS));

   assert_wrap_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (f_valid && match && !mf_start && (wp == AW'(N_WORDS - 1)) && (bp == BW'(WORD_W - 1)))
      |=> ((wp == '0) && (bp == '0)));

   assert_skip_hold_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (f_valid && !match && !mf_start) |=> ($stable(wp) && $stable(bp)));

   assert_idle_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !f_valid |=> ($stable(wp) && $stable(bp)));

   assert_resync_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (f_valid && mf_start && match) |=> ((wp == '0) && (bp == BW'(1))));

   assert_resync_skip_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (f_valid && mf_start && !match) |=> ((wp == '0) && (bp == '0)));

endmodule

// File: rtl/fbit_bit_ins.sv
module fbit_bit_ins #(
   parameter int WORD_W    = 6,
   parameter int BW        = 3,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              f_valid,
   input  logic              match,
   input  logic              first_bit,
   input  logic [BW-1:0]     bit_idx,
   input  logic [WORD_W-1:0] load_word,
   input  logic [WORD_W-1:0] bit_en,
   input  logic              f_in,
   output logic              f_out,
   output logic              f_out_vld
);

   logic [WORD_W-1:0] hold;
   logic [WORD_W-1:0] word_now;
   logic [BW-1:0]     sel;
   logic              pat_bit;
   logic              en_bit;
   logic              ins_bit;
   logic              capture;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sel = BW'(WORD_W - 1) - bit_idx;
      end else begin : g_lsb
         assign sel = bit_idx;
      end
   endgenerate

   assign capture  = f_valid && match && first_bit;
   assign word_now = first_bit ? load_word : hold;
   assign pat_bit  = word_now[sel];
   assign en_bit   = bit_en[bit_idx];
   assign ins_bit  = (match && en_bit) ? pat_bit : f_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold      <= '0;
         f_out     <= 1'b0;
         f_out_vld <= 1'b0;
      end else begin
         f_out_vld <= f_valid;
         if (f_valid)
            f_out <= ins_bit;
         if (capture)
            hold <= load_word;
      end
   end

   assert_masked_pass_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (f_valid && match && !bit_en[bit_idx]) |=> (f_out == $past(f_in)));

   assert_word_frozen_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(hold));

   assert_idle_out_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !f_valid |=> (!f_out_vld && $stable(f_out)));

endmodule

// File: rtl/fbit_pattern_ins.sv
module fbit_pattern_ins
   import fbit_ins_pkg::*;
#(
   parameter int WORD_W    = 6,
   parameter int N_WORDS   = 6,
   parameter bit MSB_FIRST = 1'b1,
   parameter int AW        = idx_w(N_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              odd_sel,
   input  logic [WORD_W-1:0] bit_en,
   input  logic              f_valid,
   input  logic              frame_odd,
   input  logic              mf_start,
   input  logic              f_in,
   output logic              f_out,
   output logic              f_out_vld
);

   localparam int BW      = idx_w(WORD_W);
   localparam int PAT_LEN = WORD_W * N_WORDS;

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("WORD_W must be at least 2");
      end
      if (N_WORDS < 2) begin : g_bad_depth
         $error("N_WORDS must be at least 2");
      end
      if ((1 << AW) < N_WORDS) begin : g_bad_aw
         $error("AW too narrow for N_WORDS");
      end
      if (PAT_LEN > 4096) begin : g_bad_len
         $error("pattern length out of range");
      end
   endgenerate

   fpar_e         want_par;
   fpar_e         frame_par;
   logic          match;
   logic [AW-1:0] word_idx;
   logic [BW-1:0] bit_idx;
   logic          first_bit;
   logic [WORD_W-1:0] load_word;

   assign want_par  = fpar_e'(odd_sel);
   assign frame_par = fpar_e'(frame_odd);
   assign match     = (want_par == frame_par);

   fbit_pat_store #(
      .WORD_W  (WORD_W),
      .N_WORDS (N_WORDS),
      .AW      (AW)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (word_idx),
      .rd_word (load_word)
   );

   fbit_pat_ptr #(
      .WORD_W  (WORD_W),
      .N_WORDS (N_WORDS),
      .AW      (AW),
      .BW      (BW)
   ) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .f_valid   (f_valid),
      .match     (match),
      .mf_start  (mf_start),
      .word_idx  (word_idx),
      .bit_idx   (bit_idx),
      .first_bit (first_bit)
   );

   fbit_bit_ins #(
      .WORD_W    (WORD_W),
      .BW        (BW),
      .MSB_FIRST (MSB_FIRST)
   ) u_ins (
      .clk       (clk),
      .rst_n     (rst_n),
      .f_valid   (f_valid),
      .match     (match),
      .first_bit (first_bit),
      .bit_idx   (bit_idx),
      .load_word (load_word),
      .bit_en    (bit_en),
      .f_in      (f_in),
      .f_out     (f_out),
      .f_out_vld (f_out_vld)
   );

   assert_parity_pass_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (f_valid && (frame_odd != odd_sel)) |=> (f_out == $past(f_in)));

   assert_out_follows_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      f_valid |=> f_out_vld);

endmodule

// File: tb/sim_fbit_pattern_ins.sv
module sim_fbit_pattern_ins;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [5:0] wr_data = '0;
   logic       odd_sel = 1'b0;
   logic [5:0] bit_en = '1;
   logic       f_valid = 1'b0;
   logic       frame_odd = 1'b0;
   logic       mf_start = 1'b0;
   logic       f_in = 1'b0;
   logic       f_out;
   logic       f_out_vld;

   int n_chk = 0;
   int n_bad = 0;

   // independent model state
   logic [5:0] mbuf [6];
   int         mw = 0;
   int         mb = 0;
   logic [5:0] mhold = '0;
   bit         msel = 1'b0;
   logic [5:0] mmask = '1;
   bit         mlast = 1'b0;

   always #(CLK_P / 2) clk = ~clk;

   fbit_pattern_ins u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .odd_sel   (odd_sel),
      .bit_en    (bit_en),
      .f_valid   (f_valid),
      .frame_odd (frame_odd),
      .mf_start  (mf_start),
      .f_in      (f_in),
      .f_out     (f_out),
      .f_out_vld (f_out_vld)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cfg(input bit sel, input logic [5:0] mask);
      odd_sel = sel;
      bit_en  = mask;
      msel    = sel;
      mmask   = mask;
   endtask

   // one clock: drive at a falling edge, check at the next falling edge
   task automatic step(input bit fv, input bit odd, input bit fin, input bit mf,
                       input bit we, input logic [2:0] wa, input logic [5:0] wd,
                       input string tag);
      int  ew;
      int  eb;
      bit  exp;
      string t;
      f_valid   = fv;
      frame_odd = odd;
      f_in      = fin;
      mf_start  = mf;
      wr_en     = we;
      wr_addr   = wa;
      wr_data   = wd;
      @(negedge clk);
      if (fv) begin
         ew = mf ? 0 : mw;
         eb = mf ? 0 : mb;
         if (odd == msel) begin
            if (eb == 0)
               mhold = (we && (int'(wa) == ew)) ? wd : mbuf[ew];
            if (mmask[eb]) begin
               exp = mhold[5 - eb];
               t   = tag;
            end else begin
               exp = fin;
               t   = "R7";
            end
            eb++;
            if (eb == 6) begin
               eb = 0;
               ew = (ew + 1) % 6;
            end
         end else begin
            exp = fin;
            t   = "R5";
         end
         mw    = ew;
         mb    = eb;
         mlast = exp;
         chk(f_out_vld === 1'b1 && f_out === exp, t, int'({f_out_vld, f_out}), int'({1'b1, exp}));
      end else begin
         chk(f_out_vld === 1'b0 && f_out === mlast, "R10", int'({f_out_vld, f_out}), int'({1'b0, mlast}));
      end
      if (we && (int'(wa) < 6))
         mbuf[wa] = wd;
      f_valid  = 1'b0;
      mf_start = 1'b0;
      wr_en    = 1'b0;
   endtask

   task automatic pw(input logic [2:0] a, input logic [5:0] d);
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, a, d, "R2");
   endtask

   task automatic t_reset();
      for (int i = 0; i < 6; i++) mbuf[i] = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(f_out === 1'b0 && f_out_vld === 1'b0, "R1", int'({f_out_vld, f_out}), 0);
      cfg(1'b0, 6'h3F);
      // empty pattern overrides a 1 on a selected frame
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0, "R1");
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0, "R1");
   endtask

   task automatic t_pattern_wrap();
      pw(3'd0, 6'h2D); pw(3'd1, 6'h13); pw(3'd2, 6'h38);
      pw(3'd3, 6'h07); pw(3'd4, 6'h2A); pw(3'd5, 6'h15);
      pw(3'd6, 6'h3F); pw(3'd7, 6'h3F);
      cfg(1'b0, 6'h3F);
      for (int i = 0; i < 84; i++) begin
         bit odd = i[0];
         step(1'b1, odd, i[1] ^ i[3], (i == 0), 1'b0, '0, '0, (i < 72) ? "R3" : "R4");
         if (i % 9 == 4) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R10");
      end
   endtask

   task automatic t_odd_select();
      cfg(1'b1, 6'h3F);
      for (int i = 0; i < 24; i++)
         step(1'b1, ~i[0], i[2], (i == 0), 1'b0, '0, '0, "R6");
   endtask

   task automatic t_mask();
      cfg(1'b0, 6'b101001);
      for (int i = 0; i < 30; i++)
         step(1'b1, 1'b0, i[0] ^ i[2] ^ 1'b1, (i == 0), 1'b0, '0, '0, "R3");
      cfg(1'b0, 6'h3F);
   endtask

   task automatic t_midword_write();
      step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0, '0, "R8");
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R8");
      pw(3'd0, ~mbuf[0]);
      for (int i = 0; i < 4; i++)
         step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0, "R8");
      // run until word 0 is sent again, now with the new value
      for (int i = 0; i < 36; i++)
         step(1'b1, 1'b0, i[0], 1'b0, 1'b0, '0, '0, "R8");
   endtask

   task automatic t_collision();
      // place pointer at the first bit of word 1
      step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0, '0, "R9");
      for (int i = 0; i < 5; i++)
         step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R3");
      // write word 1 in the very cycle its first bit is sent
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, ~mbuf[1], "R8");
      for (int i = 0; i < 5; i++)
         step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0, "R8");
      // first bit of word 2 while a different word is written
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 6'h1B, "R8");
      for (int i = 0; i < 5; i++)
         step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R8");
   endtask

   task automatic t_resync();
      step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0, '0, "R9");
      for (int i = 0; i < 8; i++)
         step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0, "R9");
      // strobe on a frame of the other parity mid-word
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0, '0, "R9");
      for (int i = 0; i < 7; i++)
         step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R9");
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R10");
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R10");
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_pattern_wrap();
      t_odd_select();
      t_mask();
      t_midword_write();
      t_collision();
      t_resync();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule